// File: doc/BRIEF.md
# Descriptor Ring Packet DMA Queue

This block runs one transmit ring and one receive ring of 64-bit descriptors. Both rings are held in a small on-chip entry memory that software fills through a window of the register bus. Each ring has a configuration register that gives its first entry index and its length in entries. Software posts transmit work and hands back free receive buffers by writing counts to two doorbell registers. The block then walks each ring in order and wraps to the first entry after the last one.

For each transmit entry the block issues one data request that carries the entry's buffer address, length and timestamp flag, and holds it until an acknowledge arrives. It keeps an outstanding count and a completion count, and it raises a full flag so that one slot is always held in reserve. An incoming receive packet is announced by its total length and an error code. The block spreads the packet over as many returned buffers as it needs and issues one data request per entry. It then writes each entry back with the bytes placed in it and a completion code, and counts finished packets. It never touches an entry that software has not returned.

Top module: `dma_ring_queue`

## Requirements
- R1: A descriptor is laid out as follows: bits 63:62 are zero, length in bits 61:48, timestamp request in bit 47, completion code in bits 46:40, buffer address in bits 39:0. Register offset 0x80+i reads and writes memory entry i.
- R2: The configuration registers (offset 0 for transmit, 3 for receive) hold the first entry index in bits 4:0 and the ring size in bits 37:32. Ring position k uses memory entry base+k.
- R3: Writing N to the transmit doorbell (offset 1) adds N to the outstanding count. Each completed transmit entry subtracts one. Reading offset 1 returns the count.
- R4: tx_full_o is high exactly when the outstanding count is at least ring size minus one.
- R5: Transmit entries are served in ring order and wrap to position 0 after position size-1. Each one produces a request carrying that entry's address, length and timestamp bit, held steady until tx_ack_i.
- R6: The transmit completion count (offset 2) rises by one per acknowledged entry. A write subtracts the written value, so writing back the value read clears it.
- R7: Writing N to the receive doorbell (offset 4) adds N free entries, and each filled entry uses one. When none are free, no receive request is made and the packet waits.
- R8: Each receive entry takes the smaller of the remaining packet bytes and the entry's length field. It is written back with that byte count and code 16 when more follows, 15 on the last entry of a good packet, or rx_pkt_err_i on the last entry when that is nonzero.
- R9: The receive packet count (offset 5) rises by one per finished packet, and a write subtracts the written value.
- R10: After reset all counts read zero and no request is active.
- R11: rx_pkt_done_o pulses for one cycle after the last entry of a packet is acknowledged, and the packet inputs are then taken as consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register or entry-window offset |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data for bus_addr_i |
| tx_req_o | output | 1 | Transmit data request |
| tx_addr_o | output | 40 | Transmit buffer address |
| tx_len_o | output | 14 | Transmit length |
| tx_tstamp_o | output | 1 | Timestamp request of the entry |
| tx_ack_i | input | 1 | Transmit data done |
| tx_full_o | output | 1 | Transmit ring full (one slot kept in reserve) |
| rx_pkt_valid_i | input | 1 | A receive packet is waiting |
| rx_pkt_len_i | input | 16 | Total packet length in bytes |
| rx_pkt_err_i | input | 7 | Error code of the packet, 0 when good |
| rx_pkt_done_o | output | 1 | Packet fully placed |
| rx_req_o | output | 1 | Receive data request |
| rx_addr_o | output | 40 | Receive buffer address |
| rx_len_o | output | 14 | Bytes to place in this buffer |
| rx_ack_i | input | 1 | Receive data done |

## Verification
A wrong ring index shows up on the very next data request as a wrong buffer address, or after a wrap as a repeated or skipped entry. A wrong count shows up on the next register read, or as a full flag that stays asserted or clear one doorbell too long. A bad split point or completion code is visible when the written-back receive entries are read as soon as the packet-done pulse has been seen. A receive engine that ignores its free count makes a request within a cycle of running dry, while the packet should wait.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int LEN_W  = 14;
  localparam int CODE_W = 7;
  localparam int BADR_W = 40;

  typedef struct packed {
    logic [1:0]        rsvd;
    logic [LEN_W-1:0]  len;
    logic              tstamp;
    logic [CODE_W-1:0] code;
    logic [BADR_W-1:0] addr;
  } ring_entry_t;

  localparam logic [CODE_W-1:0] CODE_MORE = 7'd16;
  localparam logic [CODE_W-1:0] CODE_LAST = 7'd15;

  typedef enum logic [2:0] {
    REG_TX_CFG  = 3'd0,
    REG_TX_BELL = 3'd1,
    REG_TX_DONE = 3'd2,
    REG_RX_CFG  = 3'd3,
    REG_RX_BELL = 3'd4,
    REG_RX_PKTS = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/dma_ring_mem.sv
module dma_ring_mem
  import dma_ring_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        bus_we_i,
  input  logic [AW-1:0] bus_idx_i,
  input  ring_entry_t bus_wdata_i,
  output ring_entry_t bus_rdata_o,
  input  logic [AW-1:0] tx_idx_i,
  output ring_entry_t tx_rdata_o,
  input  logic [AW-1:0] rx_idx_i,
  output ring_entry_t rx_rdata_o,
  input  logic        rx_we_i,
  input  ring_entry_t rx_wdata_i
);
  ring_entry_t mem_q [DEPTH];

  // engine write-back wins over a bus write to the same entry
  always_ff @(posedge clk_i) begin
    if (bus_we_i && !(rx_we_i && rx_idx_i == bus_idx_i)) mem_q[bus_idx_i] <= bus_wdata_i;
    if (rx_we_i) mem_q[rx_idx_i] <= rx_wdata_i;
  end

  assign bus_rdata_o = mem_q[bus_idx_i];
  assign tx_rdata_o  = mem_q[tx_idx_i];
  assign rx_rdata_o  = mem_q[rx_idx_i];
endmodule

// File: rtl/dma_tx_engine.sv
module dma_tx_engine
  import dma_ring_pkg::*;
#(
  parameter int AW    = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    base_i,
  input  logic [AW:0]      size_i,
  input  logic             bell_we_i,
  input  logic [CNT_W-1:0] bell_val_i,
  input  logic             done_we_i,
  input  logic [CNT_W-1:0] done_val_i,
  input  ring_entry_t      entry_i,
  output logic [AW-1:0]    entry_idx_o,
  output logic             req_o,
  output logic [BADR_W-1:0] addr_o,
  output logic [LEN_W-1:0] len_o,
  output logic             tstamp_o,
  input  logic             ack_i,
  output logic [CNT_W-1:0] out_cnt_o,
  output logic [CNT_W-1:0] done_cnt_o,
  output logic             full_o
);
  logic             busy_q;
  logic [AW-1:0]    idx_q;
  logic [CNT_W-1:0] out_q, done_q;
  logic             start, fin;

  assign start = !busy_q && out_q != '0 && size_i != '0;
  assign fin   = busy_q && ack_i;
  assign entry_idx_o = base_i + idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      out_q    <= '0;
      done_q   <= '0;
      addr_o   <= '0;
      len_o    <= '0;
      tstamp_o <= 1'b0;
    end else begin
      if (start) begin
        busy_q   <= 1'b1;
        addr_o   <= entry_i.addr;
        len_o    <= entry_i.len;
        tstamp_o <= entry_i.tstamp;
      end else if (fin) begin
        busy_q <= 1'b0;
        if (({1'b0, idx_q} + (AW+1)'(1)) >= size_i) idx_q <= '0;
        else idx_q <= idx_q + 1'b1;
      end
      out_q  <= out_q + (bell_we_i ? bell_val_i : '0) - CNT_W'(fin);
      done_q <= done_q - (done_we_i ? done_val_i : '0) + CNT_W'(fin);
    end
  end

  assign req_o      = busy_q;
  assign out_cnt_o  = out_q;
  assign done_cnt_o = done_q;
  assign full_o     = ({1'b0, out_q} + (CNT_W+1)'(1)) >= (CNT_W+1)'(size_i);

  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(len_o)));
  a_r3_out_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !bell_we_i) |=> (out_q == $past(out_q) - CNT_W'(1)));
  a_r6_done_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !done_we_i) |=> (done_q == $past(done_q) + CNT_W'(1)));
endmodule

// File: rtl/dma_rx_engine.sv
module dma_rx_engine
  import dma_ring_pkg::*;
#(
  parameter int AW     = 5,
  parameter int CNT_W  = 16,
  parameter int PLEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     base_i,
  input  logic [AW:0]       size_i,
  input  logic              bell_we_i,
  input  logic [CNT_W-1:0]  bell_val_i,
  input  logic              pkts_we_i,
  input  logic [CNT_W-1:0]  pkts_val_i,
  input  ring_entry_t       entry_i,
  output logic [AW-1:0]     entry_idx_o,
  output logic              entry_we_o,
  output ring_entry_t       entry_o,
  input  logic              pkt_valid_i,
  input  logic [PLEN_W-1:0] pkt_len_i,
  input  logic [CODE_W-1:0] pkt_err_i,
  output logic              pkt_done_o,
  output logic              req_o,
  output logic [BADR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  input  logic              ack_i,
  output logic [CNT_W-1:0]  free_cnt_o,
  output logic [CNT_W-1:0]  pkt_cnt_o
);
  logic              busy_q, in_pkt_q, last_q, done_q;
  logic [AW-1:0]     idx_q;
  logic [PLEN_W-1:0] rem_q, rem_next_q, cur_rem, cap;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  free_q, pkts_q;
  logic              start, fin, last_c;
  logic [LEN_W-1:0]  place_c;

  assign cur_rem = in_pkt_q ? rem_q : pkt_len_i;
  assign cap     = PLEN_W'(entry_i.len);
  assign last_c  = cur_rem <= cap;
  assign place_c = last_c ? LEN_W'(cur_rem) : entry_i.len;
  assign start   = !busy_q && !done_q && pkt_valid_i && free_q != '0 && size_i != '0;
  assign fin     = busy_q && ack_i;
  assign entry_idx_o = base_i + idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      in_pkt_q   <= 1'b0;
      last_q     <= 1'b0;
      done_q     <= 1'b0;
      idx_q      <= '0;
      rem_q      <= '0;
      rem_next_q <= '0;
      code_q     <= '0;
      addr_o     <= '0;
      len_o      <= '0;
      free_q     <= '0;
      pkts_q     <= '0;
    end else begin
      done_q <= fin && last_q;
      if (start) begin
        busy_q     <= 1'b1;
        addr_o     <= entry_i.addr;
        len_o      <= place_c;
        last_q     <= last_c;
        rem_next_q <= cur_rem - PLEN_W'(place_c);
        code_q     <= !last_c ? CODE_MORE : (pkt_err_i != '0 ? pkt_err_i : CODE_LAST);
      end else if (fin) begin
        busy_q   <= 1'b0;
        in_pkt_q <= !last_q;
        rem_q    <= rem_next_q;
        if (({1'b0, idx_q} + (AW+1)'(1)) >= size_i) idx_q <= '0;
        else idx_q <= idx_q + 1'b1;
      end
      free_q <= free_q + (bell_we_i ? bell_val_i : '0) - CNT_W'(fin);
      pkts_q <= pkts_q - (pkts_we_i ? pkts_val_i : '0) + CNT_W'(fin && last_q);
    end
  end

  assign entry_we_o = fin;
  assign entry_o    = '{rsvd: 2'b00, len: len_o, tstamp: 1'b0, code: code_q, addr: addr_o};
  assign req_o      = busy_q;
  assign pkt_done_o = done_q;
  assign free_cnt_o = free_q;
  assign pkt_cnt_o  = pkts_q;

  a_r7_no_fill_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (free_q != '0));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |=> !pkt_done_o);
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(len_o)));
endmodule

// File: rtl/dma_ring_queue.sv
module dma_ring_queue
  import dma_ring_pkg::*;
#(
  parameter int MEM_DEPTH = 32,
  parameter int CNT_W     = 16,
  parameter int BUS_AW    = 8,
  parameter int PLEN_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [63:0]       bus_wdata_i,
  output logic [63:0]       bus_rdata_o,
  output logic              tx_req_o,
  output logic [39:0]       tx_addr_o,
  output logic [13:0]       tx_len_o,
  output logic              tx_tstamp_o,
  input  logic              tx_ack_i,
  output logic              tx_full_o,
  input  logic              rx_pkt_valid_i,
  input  logic [PLEN_W-1:0] rx_pkt_len_i,
  input  logic [6:0]        rx_pkt_err_i,
  output logic              rx_pkt_done_o,
  output logic              rx_req_o,
  output logic [39:0]       rx_addr_o,
  output logic [13:0]       rx_len_o,
  input  logic              rx_ack_i
);
  localparam int MEM_AW = $clog2(MEM_DEPTH);
  localparam int SIZE_LSB = 32;

  logic              win_sel;
  reg_sel_e          rsel;
  logic [MEM_AW-1:0] tx_base_q, rx_base_q, tx_idx, rx_idx;
  logic [MEM_AW:0]   tx_size_q, rx_size_q;
  ring_entry_t       bus_ent, tx_ent, rx_ent, rx_wb;
  logic              rx_wb_we;
  logic [CNT_W-1:0]  tx_out, tx_done, rx_free, rx_pkts;
  logic              reg_we;

  assign win_sel = bus_addr_i[BUS_AW-1];
  assign rsel    = reg_sel_e'(bus_addr_i[2:0]);
  assign reg_we  = bus_we_i && !win_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_base_q <= '0; tx_size_q <= '0;
      rx_base_q <= '0; rx_size_q <= '0;
    end else if (reg_we) begin
      if (rsel == REG_TX_CFG) begin
        tx_base_q <= bus_wdata_i[MEM_AW-1:0];
        tx_size_q <= bus_wdata_i[SIZE_LSB +: MEM_AW+1];
      end
      if (rsel == REG_RX_CFG) begin
        rx_base_q <= bus_wdata_i[MEM_AW-1:0];
        rx_size_q <= bus_wdata_i[SIZE_LSB +: MEM_AW+1];
      end
    end
  end

  dma_ring_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk_i, .bus_we_i(bus_we_i && win_sel), .bus_idx_i(bus_addr_i[MEM_AW-1:0]),
    .bus_wdata_i(ring_entry_t'(bus_wdata_i)), .bus_rdata_o(bus_ent),
    .tx_idx_i(tx_idx), .tx_rdata_o(tx_ent),
    .rx_idx_i(rx_idx), .rx_rdata_o(rx_ent),
    .rx_we_i(rx_wb_we), .rx_wdata_i(rx_wb)
  );

  dma_tx_engine #(.AW(MEM_AW), .CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni, .base_i(tx_base_q), .size_i(tx_size_q),
    .bell_we_i(reg_we && rsel == REG_TX_BELL), .bell_val_i(bus_wdata_i[CNT_W-1:0]),
    .done_we_i(reg_we && rsel == REG_TX_DONE), .done_val_i(bus_wdata_i[CNT_W-1:0]),
    .entry_i(tx_ent), .entry_idx_o(tx_idx),
    .req_o(tx_req_o), .addr_o(tx_addr_o), .len_o(tx_len_o), .tstamp_o(tx_tstamp_o),
    .ack_i(tx_ack_i), .out_cnt_o(tx_out), .done_cnt_o(tx_done), .full_o(tx_full_o)
  );

  dma_rx_engine #(.AW(MEM_AW), .CNT_W(CNT_W), .PLEN_W(PLEN_W)) u_rx (
    .clk_i, .rst_ni, .base_i(rx_base_q), .size_i(rx_size_q),
    .bell_we_i(reg_we && rsel == REG_RX_BELL), .bell_val_i(bus_wdata_i[CNT_W-1:0]),
    .pkts_we_i(reg_we && rsel == REG_RX_PKTS), .pkts_val_i(bus_wdata_i[CNT_W-1:0]),
    .entry_i(rx_ent), .entry_idx_o(rx_idx), .entry_we_o(rx_wb_we), .entry_o(rx_wb),
    .pkt_valid_i(rx_pkt_valid_i), .pkt_len_i(rx_pkt_len_i), .pkt_err_i(rx_pkt_err_i),
    .pkt_done_o(rx_pkt_done_o), .req_o(rx_req_o), .addr_o(rx_addr_o), .len_o(rx_len_o),
    .ack_i(rx_ack_i), .free_cnt_o(rx_free), .pkt_cnt_o(rx_pkts)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (win_sel) bus_rdata_o = bus_ent;
    else begin
      unique case (rsel)
        REG_TX_CFG: begin
          bus_rdata_o[MEM_AW-1:0] = tx_base_q;
          bus_rdata_o[SIZE_LSB +: MEM_AW+1] = tx_size_q;
        end
        REG_RX_CFG: begin
          bus_rdata_o[MEM_AW-1:0] = rx_base_q;
          bus_rdata_o[SIZE_LSB +: MEM_AW+1] = rx_size_q;
        end
        REG_TX_BELL: bus_rdata_o[CNT_W-1:0] = tx_out;
        REG_TX_DONE: bus_rdata_o[CNT_W-1:0] = tx_done;
        REG_RX_BELL: bus_rdata_o[CNT_W-1:0] = rx_free;
        REG_RX_PKTS: bus_rdata_o[CNT_W-1:0] = rx_pkts;
        default: bus_rdata_o = '0;
      endcase
    end
  end

  a_r4_full_reserve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_size_q != '0 && !tx_full_o) |-> (tx_out < CNT_W'(tx_size_q) - CNT_W'(1)));
endmodule

// File: tb/dma_ring_queue_bench.sv
`timescale 1ns/1ps
module dma_ring_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        tx_req, tx_ts, tx_ack = 1'b0, tx_full;
  logic [39:0] tx_addr, rx_addr;
  logic [13:0] tx_len, rx_len;
  logic        rx_valid = 1'b0, rx_done, rx_req, rx_ack = 1'b0;
  logic [15:0] rx_plen = '0;
  logic [6:0]  rx_err = '0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [54:0] tx_exp[$];
  logic [53:0] rx_exp[$];

  always #10 clk = ~clk;

  dma_ring_queue u_dma_ring_queue (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_req_o(tx_req), .tx_addr_o(tx_addr), .tx_len_o(tx_len), .tx_tstamp_o(tx_ts),
    .tx_ack_i(tx_ack), .tx_full_o(tx_full),
    .rx_pkt_valid_i(rx_valid), .rx_pkt_len_i(rx_plen), .rx_pkt_err_i(rx_err),
    .rx_pkt_done_o(rx_done), .rx_req_o(rx_req), .rx_addr_o(rx_addr), .rx_len_o(rx_len),
    .rx_ack_i(rx_ack)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [63:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [63:0] ent(input logic [13:0] l, input logic t,
                                      input logic [6:0] c, input logic [39:0] ad);
    return {2'b00, l, t, c, ad};
  endfunction

  function automatic logic [39:0] txa(input int i); return 40'h10_0000_0000 + 40'(i) * 40'h100; endfunction
  function automatic logic [39:0] rxa(input int i); return 40'h20_0000_0000 + 40'(i) * 40'h1000; endfunction

  // transmit monitor: scoreboard compare then one-cycle ack
  initial forever begin
    @(negedge clk);
    if (tx_ack) tx_ack = 1'b0;
    else if (tx_req) begin
      if (tx_exp.size() == 0) chk("R5 unexpected tx request", {9'd0, tx_ts, tx_len, tx_addr}, 64'hX);
      else chk("R5 R1 tx request", {9'd0, tx_ts, tx_len, tx_addr}, {9'd0, tx_exp.pop_front()});
      tx_ack = 1'b1;
    end
  end

  // receive monitor
  initial forever begin
    @(negedge clk);
    if (rx_ack) rx_ack = 1'b0;
    else if (rx_req) begin
      if (rx_exp.size() == 0) chk("R7 unexpected rx request", {10'd0, rx_len, rx_addr}, 64'hX);
      else chk("R8 rx request", {10'd0, rx_len, rx_addr}, {10'd0, rx_exp.pop_front()});
      rx_ack = 1'b1;
    end
  end

  task automatic send_pkt(input logic [15:0] l, input logic [6:0] e);
    @(negedge clk); rx_valid = 1'b1; rx_plen = l; rx_err = e;
    do @(negedge clk); while (!rx_done);
    rx_valid = 1'b0;
    @(negedge clk);
    chk("R11 done pulse width", {63'd0, rx_done}, 64'd0);
  endtask

  initial begin
    logic [63:0] d;
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    bus_rd(8'd1, d); chk("R10 tx outstanding", d, 0);
    bus_rd(8'd2, d); chk("R10 tx done", d, 0);
    bus_rd(8'd4, d); chk("R10 rx free", d, 0);
    bus_rd(8'd5, d); chk("R10 rx pkts", d, 0);
    chk("R10 no requests", {62'd0, tx_req, rx_req}, 0);

    // transmit ring at entries 4..7
    bus_wr(8'd0, {26'd0, 6'd4, 27'd0, 5'd4});
    bus_rd(8'd0, d); chk("R2 tx cfg readback", d, {26'd0, 6'd4, 27'd0, 5'd4});
    for (int i = 0; i < 4; i++) bus_wr(8'h80 + 8'(4 + i), ent(14'(60 + i), i[0], 7'd0, txa(i)));
    bus_rd(8'h85, d); chk("R1 entry window readback", d, ent(14'd61, 1'b1, 7'd0, txa(1)));
    for (int i = 0; i < 3; i++) tx_exp.push_back({i[0], 14'(60 + i), txa(i)});
    bus_wr(8'd1, 64'd3);
    bus_rd(8'd1, d); chk("R3 outstanding after doorbell", d, 3);
    chk("R4 full at size-1", {63'd0, tx_full}, 1);
    repeat (20) @(negedge clk);
    bus_rd(8'd1, d); chk("R3 outstanding drained", d, 0);
    chk("R4 not full when empty", {63'd0, tx_full}, 0);
    bus_rd(8'd2, d); chk("R6 done count", d, 3);
    bus_wr(8'd2, d);
    bus_rd(8'd2, d); chk("R6 write-back clears", d, 0);
    tx_exp.push_back({1'b1, 14'd63, txa(3)});
    tx_exp.push_back({1'b0, 14'd60, txa(0)});
    bus_wr(8'd1, 64'd2);
    bus_rd(8'd1, d); chk("R4 outstanding two", d, 2);
    chk("R4 below reserve not full", {63'd0, tx_full}, 0);
    repeat (15) @(negedge clk);
    chk("R5 wrap consumed all", 64'(tx_exp.size()), 0);
    bus_rd(8'd2, d); chk("R6 done after wrap", d, 2);
    bus_wr(8'd2, 64'd1);
    bus_rd(8'd2, d); chk("R6 subtract", d, 1);

    // receive ring at entries 16..19, capacity 100 each
    bus_wr(8'd3, {26'd0, 6'd4, 27'd0, 5'd16});
    for (int i = 0; i < 4; i++) bus_wr(8'h80 + 8'(16 + i), ent(14'd100, 1'b0, 7'd0, rxa(i)));
    bus_wr(8'd4, 64'd4);
    bus_rd(8'd4, d); chk("R7 free after doorbell", d, 4);
    rx_exp.push_back({14'd100, rxa(0)});
    rx_exp.push_back({14'd100, rxa(1)});
    rx_exp.push_back({14'd50, rxa(2)});
    send_pkt(16'd250, 7'd0);
    bus_rd(8'h90, d); chk("R8 first piece continues", d, ent(14'd100, 1'b0, 7'd16, rxa(0)));
    bus_rd(8'h91, d); chk("R8 second piece continues", d, ent(14'd100, 1'b0, 7'd16, rxa(1)));
    bus_rd(8'h92, d); chk("R8 last piece good", d, ent(14'd50, 1'b0, 7'd15, rxa(2)));
    bus_rd(8'd5, d); chk("R9 one packet", d, 1);
    bus_rd(8'd4, d); chk("R7 free left", d, 1);
    rx_exp.push_back({14'd80, rxa(3)});
    send_pkt(16'd80, 7'd7);
    bus_rd(8'h93, d); chk("R8 error code on last", d, ent(14'd80, 1'b0, 7'd7, rxa(3)));
    bus_rd(8'd4, d); chk("R7 none free", d, 0);
    fork
      send_pkt(16'd40, 7'd0);
      begin
        repeat (10) @(negedge clk);
        chk("R7 stall without free entry", {63'd0, rx_req}, 0);
        rx_exp.push_back({14'd40, rxa(0)});
        bus_wr(8'd4, 64'd1);
      end
    join
    bus_rd(8'h90, d); chk("R8 wrapped entry reused", d, ent(14'd40, 1'b0, 7'd15, rxa(0)));
    bus_rd(8'd5, d); chk("R9 three packets", d, 3);
    bus_wr(8'd5, 64'd2);
    bus_rd(8'd5, d); chk("R9 subtract", d, 1);
    chk("R8 all rx requests seen", 64'(rx_exp.size()), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule